// File: doc/BRIEF.md
# Four-Phase Sampled Serial-to-Parallel Converter

This block turns a fast serial bit stream into 20-bit parallel words without ever clocking logic at the line rate. Upstream, four samplers fire on four evenly spaced phases of a clock running at one quarter of the line rate, so every clock period yields four consecutive bits. Each sampler hands over its decision as a complementary, active-low pair (a "set" line and a "clear" line). Inside the block, each pair is resolved by a modelled cross-coupled NAND set/clear latch, and the four latch bits are brought into the phase-0 clock domain.

The four resolved bits of each cycle enter a shift chain together, phase 0 first. A modulo-five cycle counter frames the words: every fifth cycle it loads the chain contents into a parallel output register and raises a one-cycle valid pulse. A sticky error flag reports any cycle in which a sampler drove both of its lines low at once. Equalization, the samplers themselves, clock recovery and symbol alignment sit outside this block.

Top module: `mp_deser`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), the output word, the valid flag and the error flag clear to 0, and every latch bit and the frame counter clear to 0.
- R2: When a phase's `set_n` bit is low and its `clr_n` bit is high, that phase's latch bit becomes 1 at the next edge.
- R3: When a phase's `clr_n` bit is low and its `set_n` bit is high, that phase's latch bit becomes 0 at the next edge.
- R4: When both lines of a phase are high, that phase's latch bit keeps its previous value.
- R5: When both lines of a phase are low (the forbidden input), that phase's latch bit becomes 1 and `latch_err` goes high at the next edge and stays high until reset.
- R6: `word_valid` is high for exactly one cycle after every fifth rising edge that follows reset release, and low at all other times.
- R7: A word holds the latch states of the five consecutive cycles before its load edge, oldest group in bits 19:16 and newest in bits 3:0; inside each 4-bit group, phase 0 sits in the highest bit and phase 3 in the lowest.
- R8: `word` keeps its value in every cycle in which `word_valid` is low.
- R9: The first word after reset carries the reset latch state (0000) in bits 19:16, followed by the latch states set by the first four edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-0 sampling clock, one quarter of the line rate |
| rst_n | input | 1 | Synchronous reset, active low |
| set_n | input | 4 | Active-low set line of each sampler, bit p from phase p |
| clr_n | input | 4 | Active-low clear line of each sampler, bit p from phase p |
| word | output | 20 | Parallel output word, earliest bit in bit 19 |
| word_valid | output | 1 | One-cycle pulse after each word load |
| latch_err | output | 1 | Sticky flag: a sampler drove both lines low |

## Verification
The assertions take the sampler lines to be already synchronous to the phase-0 clock, so that each edge sees a settled value on every `set_n`/`clr_n` pair; the stimulus drives them only on falling edges. The frame and stability checks further assume reset is held for at least one edge, which every reset in the bench does. Random stimulus draws each pair from the three legal codes and uses the forbidden both-low code only in directed cases, so the sticky error flag stays low through long stretches and its set and clear can be checked on purpose.

// File: rtl/mpd_pkg.sv
// Package: shared sizing of the four-phase deserializer.
// Assumes one sample per phase per clock and a word framed over MPD_DIV cycles.
package mpd_pkg;
    parameter int unsigned MPD_PHASES = 4;
    parameter int unsigned MPD_DIV    = 5;
    parameter int unsigned MPD_WORD_W = MPD_PHASES * MPD_DIV;
endpackage

// File: rtl/mpd_latch_bank.sv
// Module: one modelled NAND set/clear latch per sampler phase, registered
// in the phase-0 clock domain, plus a sticky flag for the forbidden input.
// Assumes set_n/clr_n are stable at each rising edge of clk.
module mpd_latch_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_n,
    input  logic [N-1:0] clr_n,
    output logic [N-1:0] q,
    output logic         err
);
    logic [N-1:0] both_low;

    // Flag phases whose pair is in the forbidden state this cycle.
    assign both_low = ~set_n & ~clr_n;

    for (genvar p = 0; p < N; p++) begin : g_ph
        // Resolve one complementary pair: set wins, clear next, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         q[p] <= 1'b0;
            else if (!set_n[p]) q[p] <= 1'b1;
            else if (!clr_n[p]) q[p] <= 1'b0;
        end
    end

    // Keep the error flag set until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          err <= 1'b0;
        else if (|both_low)  err <= 1'b1;
    end
endmodule

// File: rtl/mpd_frame_div.sv
// Module: modulo-DIV cycle counter; strobe is high in the last count.
// Assumes DIV >= 2.
module mpd_frame_div #(
    parameter int unsigned DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // Word strobe during the final count of each frame.
    assign strobe = (cnt == LAST);
endmodule

// File: rtl/mpd_packer.sv
// Module: shift chain taking N bits per cycle and a parallel output register
// loaded on the strobe. grp[N-1] is the earliest bit of the group.
// Assumes strobe is a single-cycle pulse every DIV cycles.
module mpd_packer #(
    parameter int unsigned N   = 4,
    parameter int unsigned DIV = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     grp,
    input  logic             strobe,
    output logic [N*DIV-1:0] word,
    output logic             valid
);
    localparam int unsigned W  = N * DIV;
    localparam int unsigned CH = W - N;

    logic [CH-1:0] chain;
    logic [W-1:0]  full;

    // Chain plus the current group forms the complete word.
    assign full = {chain, grp};

    // Shift one group in per cycle, oldest toward the top.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= full[CH-1:0];
    end

    // Load the output register on the strobe and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= strobe;
            if (strobe) word <= full;
        end
    end
endmodule

// File: rtl/mp_deser.sv
// Module: top of the four-phase sampled deserializer.
// Assumes all sampler pairs are already retimed to clk.
module mp_deser
    import mpd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MPD_PHASES-1:0] set_n,
    input  logic [MPD_PHASES-1:0] clr_n,
    output logic [MPD_WORD_W-1:0] word,
    output logic                  word_valid,
    output logic                  latch_err
);
    logic [MPD_PHASES-1:0] lat_q;
    logic [MPD_PHASES-1:0] grp;
    logic                  strobe;

    mpd_latch_bank #(.N(MPD_PHASES)) u_lat (
        .clk(clk), .rst_n(rst_n), .set_n(set_n), .clr_n(clr_n),
        .q(lat_q), .err(latch_err)
    );

    // Reorder so phase 0 (earliest bit) lands in the top bit of the group.
    for (genvar p = 0; p < MPD_PHASES; p++) begin : g_ord
        assign grp[MPD_PHASES-1-p] = lat_q[p];
    end

    mpd_frame_div #(.DIV(MPD_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .strobe(strobe)
    );

    mpd_packer #(.N(MPD_PHASES), .DIV(MPD_DIV)) u_pack (
        .clk(clk), .rst_n(rst_n), .grp(grp), .strobe(strobe),
        .word(word), .valid(word_valid)
    );
endmodule

// File: rtl/mp_deser_chk.sv
// Module: assertion checker for mp_deser, attached by bind below.
// Assumes reset is held low for at least one rising edge.
module mp_deser_chk #(
    parameter int unsigned N   = 4,
    parameter int unsigned DIV = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     set_n,
    input logic [N-1:0]     clr_n,
    input logic [N-1:0]     lat,
    input logic [N*DIV-1:0] word,
    input logic             word_valid,
    input logic             latch_err
);
    localparam int unsigned GW = $clog2(DIV + 2);
    logic [GW-1:0] gap;

    // Count edges since reset or since the last valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          gap <= '0;
        else if (word_valid) gap <= GW'(1);
        else                 gap <= gap + 1'b1;
    end

    for (genvar p = 0; p < N; p++) begin : g_p
        // R2
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_n[p]) |=> lat[p]);
        // R3
        clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_n[p] && !clr_n[p]) |=> !lat[p]);
        // R4
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_n[p] && clr_n[p]) |=> $stable(lat[p]));
    end

    // R5
    forbid_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~set_n & ~clr_n)) |=> latch_err);
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_err |=> latch_err);
    // R6
    valid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (gap == GW'(DIV)));
    // R6
    valid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == GW'(DIV)) |-> word_valid);
    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word));
endmodule

bind mp_deser mp_deser_chk #(.N(mpd_pkg::MPD_PHASES), .DIV(mpd_pkg::MPD_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .set_n(set_n), .clr_n(clr_n), .lat(lat_q),
    .word(word), .word_valid(word_valid), .latch_err(latch_err)
);

// File: tb/sim_mp_deser.sv
// Bench: random legal sampler codes plus directed corners, checked against
// a bench-side latch and framing model.
module sim_mp_deser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  set_n = 4'hF;
    logic [3:0]  clr_n = 4'hF;
    logic [19:0] word;
    logic        word_valid;
    logic        latch_err;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned edges = 0;
    logic [3:0]  cur;           // bench latch state, phase p in bit p
    logic [3:0]  hist [0:4];    // groups, phase 0 in bit 3
    logic [19:0] last_word;
    logic        exp_err;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mp_deser u0 (
        .clk(clk), .rst_n(rst_n), .set_n(set_n), .clr_n(clr_n),
        .word(word), .word_valid(word_valid), .latch_err(latch_err)
    );

    function automatic logic [3:0] latch_next(logic [3:0] q, logic [3:0] s, logic [3:0] c);
        logic [3:0] r;
        for (int p = 0; p < 4; p++)
            r[p] = !s[p] ? 1'b1 : (!c[p] ? 1'b0 : q[p]);
        return r;
    endfunction

    function automatic logic [3:0] to_grp(logic [3:0] q);
        return {q[0], q[1], q[2], q[3]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; set_n = 4'hF; clr_n = 4'hF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(word == 20'h0, "R1", 32'(word), 0);
        chk(word_valid == 1'b0, "R1", 32'(word_valid), 0);
        chk(latch_err == 1'b0, "R1", 32'(latch_err), 0);
        rst_n = 1'b1;
        edges = 0; cur = 4'h0; exp_err = 1'b0; last_word = 20'h0;
        for (int i = 0; i < 5; i++) hist[i] = 4'h0;
    endtask

    // Apply one cycle of inputs (driven at a falling edge) and check after it.
    task automatic step(input logic [3:0] s, input logic [3:0] c, input string req);
        logic [3:0]  nq;
        logic [19:0] ew;
        set_n = s; clr_n = c;
        @(posedge clk);
        edges++;
        nq = latch_next(cur, s, c);
        if ((~s & ~c) != 4'h0) exp_err = 1'b1;
        @(negedge clk);
        if (edges % 5 == 0) begin
            ew = {hist[(edges-5)%5], hist[(edges-4)%5], hist[(edges-3)%5],
                  hist[(edges-2)%5], hist[(edges-1)%5]};
            // R6 pulse due, R7/R9 word content and ordering
            chk(word_valid == 1'b1, "R6", 32'(word_valid), 1);
            chk(word == ew, (edges == 5) ? "R9" : req, 32'(word), 32'(ew));
            last_word = ew;
        end else begin
            // R6 no pulse, R8 word held
            chk(word_valid == 1'b0, "R6", 32'(word_valid), 0);
            chk(word == last_word, "R8", 32'(word), 32'(last_word));
        end
        chk(latch_err == exp_err, "R5", 32'(latch_err), 32'(exp_err));
        hist[edges % 5] = to_grp(nq);
        cur = nq;
    endtask

    // Random legal code per phase: set, clear or hold.
    task automatic rand_step(input string req);
        logic [3:0] s, c;
        for (int p = 0; p < 4; p++) begin
            case ($urandom_range(2))
                0:       begin s[p] = 1'b0; c[p] = 1'b1; end
                1:       begin s[p] = 1'b1; c[p] = 1'b0; end
                default: begin s[p] = 1'b1; c[p] = 1'b1; end
            endcase
        end
        step(s, c, req);
    endtask

    initial begin
        void'($urandom(32'd7711));
        do_reset();
        // R9 first word after reset, with R2 all ones
        for (int i = 0; i < 5; i++) step(4'h0, 4'hF, "R2");
        // R3 all zeros
        for (int i = 0; i < 5; i++) step(4'hF, 4'h0, "R3");
        // R7 phase 0 high only, then phase 3 high only
        for (int i = 0; i < 5; i++) step(4'hE, 4'h1, "R7");
        for (int i = 0; i < 5; i++) step(4'h7, 4'h8, "R7");
        // R4 hold the last pattern across a full frame
        for (int i = 0; i < 5; i++) step(4'hF, 4'hF, "R4");
        // R7 random legal stream
        for (int i = 0; i < 400; i++) rand_step("R7");
        // R5 forbidden input on phase 2, then random traffic keeps the flag
        step(4'hB, 4'hB, "R5");
        for (int i = 0; i < 30; i++) rand_step("R5");
        // R1 reset clears the sticky flag; R9 again
        do_reset();
        for (int i = 0; i < 200; i++) rand_step("R7");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule